// File: doc/BRIEF.md
# Legacy-Aware I/O Port Decoder

This block routes I/O-space requests to a destination among four programmable windows. Each window holds a start page and an end page, compared against address bits 24:12. It also holds separate read and write enables, a destination node and a destination link. A request presents a 25-bit port address and a read/write flag. One cycle later the block reports whether a window claims the request, which window it is, and the node and link to forward the request to. If no window claims it, a no-target flag is raised instead.

Two legacy options sit on top of the page comparison. The display option claims the legacy display port groups below 64K, whatever the page bounds are. The ISA option removes the aliased upper three quarters of every 1 KB block below 64K from the page match. When several windows claim a request, the window with the lowest index wins. The window registers are written and read through a small configuration port.

Top module: `io_port_decoder`

## Requirements
- R1: After reset every register reads zero and every request misses. While no request is presented, valid, hit and miss are low and the window, node and link outputs are zero.
- R2: Configuration select bit 0 chooses the limit register (1) or the base register (0), and the upper select bits give the window. In the base register, bit 0 is read enable, bit 1 is write enable, bit 4 is display enable, bit 5 is ISA enable and bits 24:12 are the start page. In the limit register, bits 2:0 are the node, bits 5:4 are the link and bits 24:12 are the end page. All other bits read back zero.
- R3: A window matches by page when start page ≤ A[24:12] ≤ end page, with both bounds inclusive.
- R4: A window claims a read only if its read enable is set, and a write only if its write enable is set. This applies to both page matches and display matches.
- R5: On a hit, the node, link and window outputs carry the claiming window's index and the node and link fields of its limit register.
- R6: A window whose link field is 3 (reserved) never claims a request.
- R7: With display enable set, an address below 0x10000 whose bits 9:0 lie in 0x3B0–0x3BB or 0x3C0–0x3DF is claimed even when it is outside the page bounds.
- R8: With ISA enable set, an address below 0x10000 with A[9:8] ≠ 0 does not match by page. Addresses at or above 0x10000 are not affected.
- R9: When more than one window claims a request, the lowest-index window wins.
- R10: Results appear on the clock edge after the request. The valid output is then high, and exactly one of hit and miss is high. On a miss, the window, node and link outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | {window index, limit select} |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_sel_i (combinational) |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 25 | I/O port address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_hit_o | output | 1 | A window claimed the request |
| rsp_miss_o | output | 1 | No window claimed the request |
| rsp_win_o | output | 2 | Index of the claiming window |
| rsp_node_o | output | 3 | Destination node |
| rsp_link_o | output | 2 | Destination link |

## Verification
A corrupted window register shows up right away on the configuration read port. On the request side it shows up on the very next response, as a wrong hit or miss, a wrong winner, or a wrong node and link. Wrong display or ISA decode is visible only for addresses below 64K with particular low-bit patterns. For that reason the stimulus walks the edges of both legacy port groups and the 256-byte boundaries of the 1 KB blocks. The reference model is recomputed from the written register values and compared on every response cycle, so a divergence is caught on the first request it affects.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W  = 25;
  localparam int PAGE_LO = 12;
  localparam int PAGE_W  = ADDR_W - PAGE_LO;
  localparam logic [31:0] BASE_MASK  = 32'h01FF_F033;
  localparam logic [31:0] LIMIT_MASK = 32'h01FF_F037;
  localparam logic [1:0]  LINK_RSVD  = 2'b11;

  typedef struct packed {
    logic              rd_en;
    logic              wr_en;
    logic              vga_en;
    logic              isa_en;
    logic [PAGE_W-1:0] lo_page;
    logic [PAGE_W-1:0] hi_page;
    logic [2:0]        node;
    logic [1:0]        link;
  } win_cfg_t;
endpackage

// File: rtl/io_win_regs.sv
module io_win_regs
  import io_dec_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int SEL_W = $clog2(NUM_WIN) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output win_cfg_t         cfg_o [NUM_WIN]
);
  logic [31:0] base_q  [NUM_WIN];
  logic [31:0] limit_q [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[w]  <= '0;
        limit_q[w] <= '0;
      end else if (we_i && sel_i[SEL_W-1:1] == (SEL_W-1)'(w)) begin
        if (sel_i[0]) limit_q[w] <= wdata_i & LIMIT_MASK;
        else          base_q[w]  <= wdata_i & BASE_MASK;
      end
    end

    assign cfg_o[w].rd_en   = base_q[w][0];
    assign cfg_o[w].wr_en   = base_q[w][1];
    assign cfg_o[w].vga_en  = base_q[w][4];
    assign cfg_o[w].isa_en  = base_q[w][5];
    assign cfg_o[w].lo_page = base_q[w][ADDR_W-1:PAGE_LO];
    assign cfg_o[w].hi_page = limit_q[w][ADDR_W-1:PAGE_LO];
    assign cfg_o[w].node    = limit_q[w][2:0];
    assign cfg_o[w].link    = limit_q[w][5:4];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_i[SEL_W-1:1] == (SEL_W-1)'(w))
        rdata_o = sel_i[0] ? limit_q[w] : base_q[w];
    end
  end
endmodule

// File: rtl/io_win_match.sv
module io_win_match
  import io_dec_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] page;
  logic [9:0]        low10;
  logic              below_64k, vga_port, isa_alias, in_range, access_ok;

  assign page      = addr_i[ADDR_W-1:PAGE_LO];
  assign low10     = addr_i[9:0];
  assign below_64k = (addr_i[ADDR_W-1:16] == '0);
  assign vga_port  = cfg_i.vga_en && below_64k &&
                     ((low10 >= 10'h3B0 && low10 <= 10'h3BB) ||
                      (low10 >= 10'h3C0 && low10 <= 10'h3DF));
  // upper 768 bytes of each 1 KB block
  assign isa_alias = cfg_i.isa_en && below_64k && (addr_i[9:8] != 2'b00);
  assign in_range  = (page >= cfg_i.lo_page) && (page <= cfg_i.hi_page) && !isa_alias;
  assign access_ok = write_i ? cfg_i.wr_en : cfg_i.rd_en;
  assign hit_o     = access_ok && (cfg_i.link != LINK_RSVD) && (in_range || vga_port);
endmodule

// File: rtl/io_win_arb.sv
module io_win_arb #(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hit_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign any_o = |hit_i;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = $clog2(NUM_WIN),
  localparam int SEL_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic [IDX_W-1:0]  rsp_win_o,
  output logic [2:0]        rsp_node_o,
  output logic [1:0]        rsp_link_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;

  io_win_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    io_win_match u_match (
      .cfg_i   (cfg[w]),
      .addr_i  (req_addr_i),
      .write_i (req_write_i),
      .hit_o   (hit[w])
    );
  end

  io_win_arb #(.NUM_WIN(NUM_WIN)) u_arb (
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_win_o   <= '0;
      rsp_node_o  <= '0;
      rsp_link_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && any_hit;
      rsp_miss_o  <= req_valid_i && !any_hit;
      rsp_win_o   <= (req_valid_i && any_hit) ? win_idx : '0;
      rsp_node_o  <= (req_valid_i && any_hit) ? cfg[win_idx].node : '0;
      rsp_link_o  <= (req_valid_i && any_hit) ? cfg[win_idx].link : '0;
    end
  end
endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk
  import io_dec_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W = $clog2(NUM_WIN),
  localparam int SEL_W = IDX_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [SEL_W-1:0]  cfg_sel_i,
  input logic [31:0]       cfg_wdata_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_write_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_miss_o,
  input logic [IDX_W-1:0]  rsp_win_o,
  input logic [2:0]        rsp_node_o,
  input logic [1:0]        rsp_link_o
);
  assert_valid_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_miss_o));

  assert_hit_xor_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o}) == 1);

  assert_miss_zero_fields_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_win_o == '0 && rsp_node_o == '0 && rsp_link_o == '0));

  assert_no_reserved_link_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_link_o != LINK_RSVD);

  assert_reserved_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[31:25] == '0) && (cfg_rdata_o[11:6] == '0) && !cfg_rdata_o[3] &&
    (cfg_sel_i[0] || cfg_rdata_o[2] == 1'b0));
endmodule

bind io_port_decoder io_port_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (.*);

// File: tb/io_port_decoder_tb.sv
module io_port_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [24:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [1:0]  rsp_win, rsp_link;
  logic [2:0]  rsp_node;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] base_m  [4];
  logic [31:0] limit_m [4];

  always #10 clk = ~clk;

  io_port_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .req_write_i(req_write), .rsp_valid_o(rsp_valid),
    .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_win_o(rsp_win),
    .rsp_node_o(rsp_node), .rsp_link_o(rsp_link)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {valid, hit, miss, win[1:0], node[2:0], link[1:0]}
  function automatic logic [9:0] model(input int a, input bit wr);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] b, l;
      bit en, low, vga, isa, rng;
      int lo, pg;
      b = base_m[w]; l = limit_m[w];
      en  = wr ? b[1] : b[0];
      low = (a < 65536);
      lo  = a % 1024;
      pg  = a / 4096;
      vga = b[4] && low && ((lo >= 944 && lo <= 955) || (lo >= 960 && lo <= 991));
      isa = b[5] && low && (lo >= 256);
      rng = (pg >= int'(b[24:12])) && (pg <= int'(l[24:12])) && !isa;
      if (en && l[5:4] != 2'b11 && (vga || rng))
        return {1'b1, 1'b1, 1'b0, 2'(w), l[2:0], l[5:4]};
    end
    return 10'b1_0_1_00_000_00;
  endfunction

  task automatic wr_reg(input int win, input bit lim, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {2'(win), lim}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (lim) limit_m[win] = d & 32'h01FF_F037;
    else     base_m[win]  = d & 32'h01FF_F033;
  endtask

  task automatic rd_reg(input string req, input int win, input bit lim);
    @(negedge clk);
    cfg_sel = {2'(win), lim};
    #1;
    chk(req, cfg_rdata, lim ? limit_m[win] : base_m[win]);
  endtask

  task automatic do_req(input string req, input int a, input bit wr);
    logic [9:0] exp;
    exp = model(a, wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 25'(a); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {22'b0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_node, rsp_link}, {22'b0, exp});
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R1 idle", {22'b0, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_node, rsp_link}, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 4; w++) begin base_m[w] = '0; limit_m[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int w = 0; w < 4; w++) begin rd_reg("R1 base", w, 0); rd_reg("R1 limit", w, 1); end
    do_req("R1 reset miss", 'h0, 0);
    do_req("R1 reset miss wr", 'h3C0, 1);
    idle_chk();
    // R2 masking
    wr_reg(0, 0, 32'hFFFF_FFFF); rd_reg("R2 base mask", 0, 0);
    chk("R2 base value", cfg_rdata, 32'h01FF_F033);
    wr_reg(0, 1, 32'hFFFF_FFFF); rd_reg("R2 limit mask", 0, 1);
    chk("R2 limit value", cfg_rdata, 32'h01FF_F037);
    // window setup
    wr_reg(0, 0, (32'h010 << 12) | 32'h3);
    wr_reg(0, 1, (32'h01F << 12) | 32'h12);
    wr_reg(1, 0, (32'h018 << 12) | 32'h1);
    wr_reg(1, 1, (32'h030 << 12) | 32'h25);
    wr_reg(2, 0, (32'h1F00 << 12) | 32'h13);
    wr_reg(2, 1, (32'h1F00 << 12) | 32'h03);
    wr_reg(3, 0, (32'h002 << 12) | 32'h23);
    wr_reg(3, 1, (32'h003 << 12) | 32'h27);
    for (int w = 0; w < 4; w++) begin rd_reg("R2 readback", w, 0); rd_reg("R2 readback", w, 1); end
    // R3 bounds
    do_req("R3 low edge", 'h10000, 0);
    do_req("R3 high edge", 'h1FFFF, 1);
    do_req("R3 below", 'h0FFFF, 0);
    do_req("R3 above", 'h31000, 0);
    // R9 priority and R5 fields
    do_req("R9 overlap", 'h18000, 0);
    do_req("R5 win1", 'h25000, 0);
    // R4 enables
    do_req("R4 write blocked", 'h25000, 1);
    // R7 display ports
    do_req("R7 3B0", 'h3B0, 0);
    do_req("R7 3BB", 'h3BB, 1);
    do_req("R7 3BC", 'h3BC, 0);
    do_req("R7 3C0", 'h3C0, 0);
    do_req("R7 3DF", 'h3DF, 0);
    do_req("R7 3E0", 'h3E0, 0);
    do_req("R7 alias", 'h7B0, 0);
    do_req("R7 above 64k", 'h403C0, 0);
    // R8 ISA carve
    do_req("R8 low quarter", 'h2000, 0);
    do_req("R8 last low", 'h20FF, 1);
    do_req("R8 carved", 'h2100, 0);
    do_req("R8 carved top", 'h23FF, 0);
    do_req("R8 next block", 'h2400, 0);
    wr_reg(3, 0, (32'h040 << 12) | 32'h23);
    wr_reg(3, 1, (32'h041 << 12) | 32'h27);
    do_req("R8 above 64k", 'h40100, 0);
    // R4 display respects enables
    wr_reg(2, 0, (32'h1F00 << 12) | 32'h11);
    do_req("R4 vga write blocked", 'h3C0, 1);
    do_req("R4 vga read", 'h3C0, 0);
    // R6 reserved link
    wr_reg(3, 1, (32'h041 << 12) | 32'h37);
    do_req("R6 reserved link", 'h40100, 0);
    do_req("R6 reserved link wr", 'h41FFF, 1);
    idle_chk();
    // R10 back-to-back
    do_req("R10 b2b a", 'h10000, 0);
    do_req("R10 b2b b", 'h5000, 0);
    idle_chk();
    finish_run();
  end
endmodule